// File: doc/BRIEF.md
# Asynchronous Parallel Byte Configuration Receiver

This block is the receiving end of a byte-wide, strobe-driven load port. A host writes one byte at a time over an eight-bit data bus with a write strobe. The receiver runs on its own free-running internal clock, nominally 10 MHz, which is not related to the host. For each accepted byte it goes busy for a fixed number of internal clock cycles. When the byte is done, it hands the byte to the downstream logic as a one-cycle valid/data pulse.

An active-low configuration-reset input holds the block in reset. While that input is low, the block pulls an open-drain status line low. Once the reset input rises, the block releases the line. As long as either the reset input or the sensed status line is low, the block stays in reset and ignores writes. A host can learn when to send the next byte in two ways: it can poll a dedicated ready/busy output, or it can assert a read strobe. During the read strobe the block drives the ready/busy state onto bit 7 of the data bus and leaves bits 6..0 undriven.

The write strobe and read strobe are synchronized into the internal clock domain, and edges are detected on the synchronized copies. A write strobe that arrives while the block is busy is dropped, and it sets a sticky overrun flag. The host must hold the data and the chip selects stable for at least SYNC_STAGES+1 internal clock cycles after the write strobe rises.

Top module: `cfg_byte_target`

## Requirements
- R1: While cfg_n is low or the sensed status line status_n_in is low, rdy reads 0 and a write strobe causes no busy period and no byte_valid pulse.
- R2: status_oe is 1 while cfg_n is low. Within 8 internal cycles after cfg_n rises (with the line free to go high), status_oe is 0 and rdy is 1.
- R3: In the default select mode, a byte is taken only when cs_n is 0 and cs is 1. Otherwise a write strobe leaves rdy at 1, gives no byte_valid pulse and does not set overrun.
- R4: When selected and ready, a rising edge of wr_n latches data_i and drives rdy to 0 within SYNC_STAGES+2 internal cycles.
- R5: rdy stays 0 for exactly BUSY_CYCLES internal clock cycles for each accepted byte.
- R6: In the first cycle in which rdy returns to 1, byte_valid is 1 for that single cycle and byte_data equals the latched byte.
- R7: A write strobe edge that arrives while busy is ignored: no extra byte_valid pulse and no change to the byte being processed. It sets overrun to 1, and overrun stays 1 until the block re-enters reset.
- R8: While rd_n is low (after SYNC_STAGES cycles of latency), bus_oe equals 8'h80 and bus_o[7] equals rdy. While rd_n is high, bus_oe is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| cfg_n | input | 1 | Active-low configuration reset, asynchronous |
| status_n_in | input | 1 | Sensed level of the open-drain status line |
| status_oe | output | 1 | When 1, the status line is pulled low |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| wr_n | input | 1 | Write strobe; byte taken on its rising edge |
| rd_n | input | 1 | Read strobe; ready state shown on bus bit 7 while low |
| data_i | input | DATA_W | Data bus as seen from pins |
| bus_o | output | DATA_W | Value driven on data bus |
| bus_oe | output | DATA_W | Per-bit drive enable for the data bus |
| rdy | output | 1 | 1 = ready for a byte, 0 = busy or in reset |
| overrun | output | 1 | Sticky flag: a write arrived while busy |
| byte_valid | output | 1 | One-cycle pulse when a byte finishes processing |
| byte_data | output | DATA_W | Byte presented with byte_valid |

## Verification
If the busy counter is corrupted, the fault shows on rdy as a busy window of the wrong length within one byte period. Because byte_valid is timed off the same counter, it then also lands on the wrong cycle. A latched byte that is lost or overwritten shows on byte_data at the end of the busy window of that same byte. A bad edge detector or a select decode error shows within SYNC_STAGES+2 cycles of the strobe, as a missing busy period, an extra one, or a false overrun. A fault in the status or reset path keeps rdy low or status_oe high after cfg_n is released, and this is visible within a few cycles.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
   typedef enum logic [1:0] {
      CS_BOTH = 2'd0,
      CS_LOW_ONLY = 2'd1,
      CS_HIGH_ONLY = 2'd2
   } cs_mode_e;
endpackage

// File: rtl/cbt_sync.sv
module cbt_sync #(
   parameter int STAGES = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("cbt_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= {STAGES{RST_VAL}};
      else         chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cbt_strobe_front.sv
module cbt_strobe_front
   import cbt_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter cs_mode_e CS_MODE = CS_BOTH
) (
   input  logic clk,
   input  logic arst_n,
   input  logic wr_n,
   input  logic rd_n,
   input  logic cs_n,
   input  logic cs,
   output logic wr_rise,
   output logic rd_active,
   output logic chip_sel
);
   logic wr_s, rd_s, wr_prev;

   cbt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_wr_sync (
      .clk(clk), .arst_n(arst_n), .d(wr_n), .q(wr_s));
   cbt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rd_sync (
      .clk(clk), .arst_n(arst_n), .d(rd_n), .q(rd_s));

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) wr_prev <= 1'b1;
      else         wr_prev <= wr_s;
   end

   assign wr_rise   = wr_s & ~wr_prev;
   assign rd_active = ~rd_s;

   generate
      if (CS_MODE == CS_LOW_ONLY) begin : g_cs_low
         assign chip_sel = ~cs_n;
      end else if (CS_MODE == CS_HIGH_ONLY) begin : g_cs_high
         assign chip_sel = cs;
      end else begin : g_cs_both
         assign chip_sel = ~cs_n & cs;
      end
   endgenerate
endmodule

// File: rtl/cbt_busy_engine.sv
module cbt_busy_engine #(
   parameter int DATA_W = 8,
   parameter int BUSY_CYCLES = 16
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              srst,
   input  logic              take,
   input  logic [DATA_W-1:0] din,
   output logic              busy,
   output logic              ovr,
   output logic              vld,
   output logic [DATA_W-1:0] dout
);
   localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] hold;

   generate
      if (BUSY_CYCLES < 1) begin : g_bad
         $error("cbt_busy_engine: BUSY_CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         busy <= 1'b0;
         ovr  <= 1'b0;
         vld  <= 1'b0;
         cnt  <= '0;
         hold <= '0;
         dout <= '0;
      end else if (srst) begin
         busy <= 1'b0;
         ovr  <= 1'b0;
         vld  <= 1'b0;
         cnt  <= '0;
         hold <= '0;
         dout <= '0;
      end else begin
         vld <= 1'b0;
         if (busy) begin
            if (take) ovr <= 1'b1;
            if (cnt == '0) begin
               busy <= 1'b0;
               vld  <= 1'b1;
               dout <= hold;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end else if (take) begin
            busy <= 1'b1;
            hold <= din;
            cnt  <= CNT_LOAD;
         end
      end
   end
endmodule

// File: rtl/cfg_byte_target.sv
module cfg_byte_target
   import cbt_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SYNC_STAGES = 2,
   parameter int BUSY_CYCLES = 16,
   parameter cs_mode_e CS_MODE = CS_BOTH
) (
   input  logic              clk,
   input  logic              cfg_n,
   input  logic              status_n_in,
   output logic              status_oe,
   input  logic              cs_n,
   input  logic              cs,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] bus_o,
   output logic [DATA_W-1:0] bus_oe,
   output logic              rdy,
   output logic              overrun,
   output logic              byte_valid,
   output logic [DATA_W-1:0] byte_data
);
   localparam int FLAG_BIT = DATA_W - 1;
   localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << FLAG_BIT;

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("cfg_byte_target: DATA_W must be at least 2");
      end
   endgenerate

   logic cfg_s, stat_s, core_rst;
   logic wr_rise, rd_active, chip_sel, busy;

   cbt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cfg_sync (
      .clk(clk), .arst_n(cfg_n), .d(1'b1), .q(cfg_s));
   cbt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_stat_sync (
      .clk(clk), .arst_n(cfg_n), .d(status_n_in), .q(stat_s));

   assign core_rst  = ~cfg_s | ~stat_s;
   assign status_oe = ~cfg_s;

   cbt_strobe_front #(.SYNC_STAGES(SYNC_STAGES), .CS_MODE(CS_MODE)) u_front (
      .clk(clk), .arst_n(cfg_n), .wr_n(wr_n), .rd_n(rd_n),
      .cs_n(cs_n), .cs(cs), .wr_rise(wr_rise),
      .rd_active(rd_active), .chip_sel(chip_sel));

   cbt_busy_engine #(.DATA_W(DATA_W), .BUSY_CYCLES(BUSY_CYCLES)) u_engine (
      .clk(clk), .arst_n(cfg_n), .srst(core_rst),
      .take(wr_rise & chip_sel), .din(data_i),
      .busy(busy), .ovr(overrun), .vld(byte_valid), .dout(byte_data));

   assign rdy    = ~busy & ~core_rst;
   assign bus_oe = rd_active ? FLAG_MASK : '0;
   assign bus_o  = rdy ? FLAG_MASK : '0;
endmodule

// File: rtl/cfg_byte_target_chk.sv
module cfg_byte_target_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              cfg_n,
   input logic              core_rst,
   input logic              status_oe,
   input logic              rdy,
   input logic              overrun,
   input logic              byte_valid,
   input logic [DATA_W-1:0] byte_data
);
   // R1
   status_hold_chk: assert property (@(posedge clk) disable iff (!cfg_n)
      status_oe |-> !rdy);

   // R6
   valid_after_busy_chk: assert property (@(posedge clk) disable iff (core_rst)
      byte_valid |-> $past(!rdy));

   // R6
   valid_single_chk: assert property (@(posedge clk) disable iff (core_rst)
      byte_valid |=> !byte_valid);

   // R6
   data_steady_chk: assert property (@(posedge clk) disable iff (core_rst)
      (!rdy && $past(!rdy)) |-> $stable(byte_data));

   // R7
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (core_rst)
      overrun |=> overrun);

   // R7
   overrun_busy_chk: assert property (@(posedge clk) disable iff (core_rst)
      $rose(overrun) |-> $past(!rdy));
endmodule

bind cfg_byte_target cfg_byte_target_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .cfg_n(cfg_n), .core_rst(core_rst), .status_oe(status_oe),
   .rdy(rdy), .overrun(overrun), .byte_valid(byte_valid),
   .byte_data(byte_data));

// File: tb/tb_cfg_byte_target.sv
`timescale 1ns/1ps
module tb_cfg_byte_target;
   localparam int DW = 8;
   localparam int SYNC = 2;
   localparam int BUSY = 12;

   logic clk = 1'b0;
   logic cfg_n = 1'b0;
   logic ext_low = 1'b0;
   logic cs_n = 1'b1, cs = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
   logic [DW-1:0] data_i = '0;
   logic status_oe, rdy, overrun, byte_valid, status_line;
   logic [DW-1:0] bus_o, bus_oe, byte_data;

   int checks = 0;
   int errors = 0;
   int vcount = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   assign status_line = ~status_oe & ~ext_low;

   cfg_byte_target #(.DATA_W(DW), .SYNC_STAGES(SYNC), .BUSY_CYCLES(BUSY)) dut (
      .clk(clk), .cfg_n(cfg_n), .status_n_in(status_line), .status_oe(status_oe),
      .cs_n(cs_n), .cs(cs), .wr_n(wr_n), .rd_n(rd_n), .data_i(data_i),
      .bus_o(bus_o), .bus_oe(bus_oe), .rdy(rdy), .overrun(overrun),
      .byte_valid(byte_valid), .byte_data(byte_data));

   always @(negedge clk) if (byte_valid) vcount++;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_wr(input logic [DW-1:0] d, input logic sel);
      @(negedge clk);
      data_i = d; cs_n = ~sel; cs = sel;
      wr_n = 1'b0;
      cyc(2);
      wr_n = 1'b1;
   endtask

   task automatic release_bus();
      data_i = 8'hEE; cs_n = 1'b1; cs = 1'b0;
   endtask

   // Wait until busy; returns number of cycles waited, -1 on timeout
   task automatic wait_busy(output int waited);
      waited = -1;
      for (int i = 0; i < SYNC + 4; i++) begin
         @(negedge clk);
         if (!rdy) begin waited = i; break; end
      end
   endtask

   task automatic t_reset();
      cyc(1);
      check(rdy == 1'b0, "R1 rdy in reset", rdy, 0);
      check(status_oe == 1'b1, "R2 status driven in reset", status_oe, 1);
      check(bus_oe == '0, "R8 bus idle in reset", bus_oe, 0);
      check(byte_valid == 1'b0, "R6 no valid in reset", byte_valid, 0);
      cfg_n = 1'b1;
      cyc(8);
      check(status_oe == 1'b0, "R2 status released", status_oe, 0);
      check(rdy == 1'b1, "R2 ready after release", rdy, 1);
      check(overrun == 1'b0, "R7 overrun clear after reset", overrun, 0);
   endtask

   task automatic t_write(input logic [DW-1:0] d);
      int w, cnt, v0;
      v0 = vcount;
      pulse_wr(d, 1'b1);
      wait_busy(w);
      check(w >= 0, "R4 busy after write", w, 0);
      release_bus();
      cnt = 1;
      while (!rdy && cnt < BUSY + 5) begin
         @(negedge clk);
         if (!rdy) cnt++;
      end
      check(cnt == BUSY, "R5 busy length", cnt, BUSY);
      check(byte_valid == 1'b1, "R6 valid at ready", byte_valid, 1);
      check(byte_data == d, "R6 byte data", byte_data, d);
      @(negedge clk);
      check(byte_valid == 1'b0, "R6 valid one cycle", byte_valid, 0);
      check(vcount == v0 + 1, "R6 one pulse per byte", vcount - v0, 1);
   endtask

   task automatic t_unselected();
      int v0;
      v0 = vcount;
      pulse_wr(8'h3C, 1'b0);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (!rdy) break;
      end
      check(rdy == 1'b1, "R3 unselected write ignored", rdy, 1);
      check(vcount == v0, "R3 no valid when unselected", vcount - v0, 0);
      check(overrun == 1'b0, "R3 no overrun when unselected", overrun, 0);
      release_bus();
   endtask

   task automatic t_overrun();
      int w, v0;
      v0 = vcount;
      pulse_wr(8'hA5, 1'b1);
      wait_busy(w);
      check(w >= 0, "R4 busy before overrun", w, 0);
      pulse_wr(8'h5A, 1'b1);
      cyc(SYNC + 3);
      check(overrun == 1'b1, "R7 overrun set", overrun, 1);
      release_bus();
      for (int i = 0; i < BUSY + 5; i++) begin
         if (rdy) break;
         @(negedge clk);
      end
      check(byte_data == 8'hA5, "R7 first byte kept", byte_data, 8'hA5);
      cyc(6);
      check(vcount == v0 + 1, "R7 dropped byte gives no pulse", vcount - v0, 1);
      check(overrun == 1'b1, "R7 overrun sticky", overrun, 1);
      check(rdy == 1'b1, "R7 ready after overrun", rdy, 1);
   endtask

   task automatic t_read();
      int w;
      rd_n = 1'b0;
      cyc(SYNC + 1);
      check(bus_oe == 8'h80, "R8 only bit 7 driven", bus_oe, 8'h80);
      check(bus_o[7] == 1'b1, "R8 ready on bit 7", bus_o[7], 1);
      pulse_wr(8'h11, 1'b1);
      wait_busy(w);
      release_bus();
      cyc(1);
      check(bus_o[7] == 1'b0 && bus_oe[7], "R8 busy on bit 7", bus_o[7], 0);
      rd_n = 1'b1;
      cyc(SYNC + 1);
      check(bus_oe == 8'h00, "R8 bus released", bus_oe, 0);
      cyc(BUSY + 4);
   endtask

   task automatic t_hold_reset();
      int v0;
      cfg_n = 1'b0;
      cyc(2);
      v0 = vcount;
      pulse_wr(8'h77, 1'b1);
      cyc(BUSY + 4);
      check(rdy == 1'b0, "R1 no ready in reset", rdy, 0);
      check(vcount == v0, "R1 write ignored in reset", vcount - v0, 0);
      check(status_oe == 1'b1, "R2 status driven", status_oe, 1);
      release_bus();
      cfg_n = 1'b1;
      cyc(8);
      check(rdy == 1'b1, "R2 ready after second release", rdy, 1);
      check(overrun == 1'b0, "R7 overrun cleared by reset", overrun, 0);
      ext_low = 1'b1;
      cyc(SYNC + 2);
      check(rdy == 1'b0, "R1 status low holds reset", rdy, 0);
      v0 = vcount;
      pulse_wr(8'h99, 1'b1);
      cyc(BUSY + 4);
      check(vcount == v0, "R1 write ignored while status low", vcount - v0, 0);
      release_bus();
      ext_low = 1'b0;
      cyc(SYNC + 3);
      check(rdy == 1'b1, "R1 ready after status free", rdy, 1);
      cyc(BUSY + 2);
      check(vcount == v0, "R1 no late byte", vcount - v0, 0);
   endtask

   initial begin
      t_reset();
      t_write(8'hC3);
      t_write(8'h00);
      t_write(8'hFF);
      t_unselected();
      t_overrun();
      t_read();
      t_hold_reset();
      t_write(8'h6D);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule